// File: doc/BRIEF.md
# Counter Array Compare and Watchdog

This block holds one 16-bit up-counter and five compare channels. The counter advances once per peripheral cycle of six clock states while its run bit is set. Each channel compares the counter with its own 16-bit compare value and raises a flag when they are equal. Software can clear a flag, but not during the peripheral cycle that follows the hardware setting it. The interrupt request is the OR of every flag whose channel has its interrupt enable set.

The last channel can also serve as a software watchdog. When the watchdog enable is set and that channel matches, the block emits a one-cycle reset pulse. A match is only evaluated in the cycle after the counter register or a compare register is updated. Because of this, the match that exists right after reset (counter 0, compare 0) cannot fire the watchdog while it is being set up.

Top module: `pca_cmp_wdt`

Register map (8-bit address, 8-bit data, writes only):

| Address | Contents |
|---|---|
| 0x00 | control: bit 7 run, bits 4:0 flags (write 0 clears, write 1 keeps) |
| 0x01 / 0x02 | counter low / high byte |
| 0x03 | bit 0 watchdog enable |
| 0x10 + n | channel n mode: bit 2 compare enable, bit 1 match enable, bit 0 interrupt enable |
| 0x20 + 2n / 0x21 + 2n | channel n compare low / high byte |

## Requirements
- R1: After reset the counter reads 0x0000, all flags are 0, and irq_o and wdt_rst_o are 0.
- R2: A write to address 0x01 or 0x02 replaces the low or high counter byte. cnt_o shows the new value right after the write edge.
- R3: With the run bit (control bit 7) set, the counter increases by exactly one every 6 clock cycles. With the run bit clear, it holds its value.
- R4: A channel flag is set one cycle after an evaluation event when three conditions hold: the counter equals the channel's compare value, compare enable (mode bit 2) is set, and match enable (mode bit 1) is set. An evaluation event is the cycle after a counter update or a compare-high write. This applies whether or not the counter is running.
- R5: When match enable is clear, a match never sets the flag, even with the counter stopped.
- R6: Once hardware sets a flag, a software clear is ignored for the following 6 cycles. A clear issued after that window takes effect.
- R7: Writing a compare low byte clears that channel's compare enable. Writing the compare high byte sets it again and starts an evaluation.
- R8: irq_o is high exactly when some flag is set and that channel's interrupt enable (mode bit 0) is set.
- R9: If the watchdog enable (address 0x03 bit 0) is set and channel 4 matches, wdt_rst_o goes high for exactly one cycle.
- R10: Setting channel 4 to watchdog mode while the counter and compare value still hold their reset value of 0 produces no reset pulse and no flag.
- R11: Writing 1 to a flag bit of the control register leaves that flag unchanged. Software cannot set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, one state per cycle |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 8 | register address |
| wdata | input | 8 | write data |
| cnt_o | output | 16 | current counter value |
| flag_o | output | 5 | channel flags |
| irq_o | output | 1 | interrupt request |
| wdt_rst_o | output | 1 | one-cycle watchdog reset pulse |

## Verification
The assertions assume a register write lasts one cycle and that only one register is written per cycle. The bench writes through a single task that raises wr_en for one edge, so this always holds. The assertions also assume the counter can be stepped only by a tick or a byte write. To keep evaluation events separate, the stimulus stops the counter before it loads values near a compare point. It also waits out the flag lock window on purpose before issuing the clear that is expected to take effect.

// File: rtl/pca_pkg.sv
package pca_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int ADDR_W    = 8;
    localparam int A_CTRL    = 8'h00;
    localparam int A_CNT_LO  = 8'h01;
    localparam int A_CNT_HI  = 8'h02;
    localparam int A_WDEN    = 8'h03;
    localparam int A_MODE    = 8'h10;
    localparam int A_CMP     = 8'h20;
    localparam int RUN_BIT   = 7;
    localparam int M_IE_BIT  = 0;
    localparam int M_MAT_BIT = 1;
    localparam int M_CMP_BIT = 2;
endpackage

// File: rtl/pca_prescaler.sv
module pca_prescaler #(
    parameter int PRESC = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

    typedef struct packed {
        logic [PW-1:0] ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PW'(PRESC - 1)) st_d.ph = '0;
        else                           st_d.ph = st_q.ph + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = (st_q.ph == PW'(PRESC - 1));

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.ph == '0));
endmodule

// File: rtl/pca_counter.sv
module pca_counter
    import pca_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic             upd_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             upd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (wr_lo_i) begin
            st_d.cnt[BYTE_W-1:0] = wdata_i;
            st_d.upd             = 1'b1;
        end else if (wr_hi_i) begin
            st_d.cnt[CNT_W-1:BYTE_W] = wdata_i;
            st_d.upd                 = 1'b1;
        end else if (run_i && tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign upd_o = st_q.upd;

    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_i && !wr_hi_i) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pca_channel.sv
module pca_channel
    import pca_pkg::*;
#(
    parameter int PRESC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cnt_upd_i,
    input  logic              wr_mode_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              clr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              flag_o,
    output logic              ie_o,
    output logic              hit_o
);
    localparam int LW = $clog2(PRESC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             cmp_en;
        logic             mat_en;
        logic             ie;
        logic             cmp_upd;
        logic             flag;
        logic [LW-1:0]    lock;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    assign hit = (cnt_upd_i || st_q.cmp_upd) && (cnt_i == st_q.cmp)
                 && st_q.cmp_en && st_q.mat_en;

    always_comb begin
        st_d         = st_q;
        st_d.cmp_upd = 1'b0;
        if (wr_mode_i) begin
            st_d.cmp_en = wdata_i[M_CMP_BIT];
            st_d.mat_en = wdata_i[M_MAT_BIT];
            st_d.ie     = wdata_i[M_IE_BIT];
        end
        if (wr_lo_i) begin
            st_d.cmp[BYTE_W-1:0] = wdata_i;
            st_d.cmp_en          = 1'b0;
        end
        if (wr_hi_i) begin
            st_d.cmp[CNT_W-1:BYTE_W] = wdata_i;
            st_d.cmp_en              = 1'b1;
            st_d.cmp_upd             = 1'b1;
        end
        if (st_q.lock != '0) st_d.lock = st_q.lock - 1'b1;
        if (hit) begin
            st_d.flag = 1'b1;
            st_d.lock = LW'(PRESC);
        end else if (clr_i && st_q.lock == '0) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign ie_o   = st_q.ie;
    assign hit_o  = hit;

    assert_rise_needs_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(st_q.cmp_en && st_q.mat_en));

    assert_no_early_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> ($past(st_q.lock) == '0 && $past(clr_i)));

    assert_lock_after_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> (st_q.lock == LW'(PRESC)));
endmodule

// File: rtl/pca_cmp_wdt.sv
module pca_cmp_wdt
    import pca_pkg::*;
#(
    parameter int NCH   = 5,
    parameter int PRESC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NCH-1:0]    flag_o,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    localparam int WDT_CH = NCH - 1;

    typedef struct packed {
        logic run;
        logic wden;
        logic wdt;
    } st_t;

    st_t st_d, st_q;

    logic           wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_wden;
    logic           tick, cnt_upd;
    logic [NCH-1:0] ie, hit;

    assign wr_ctrl   = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_cnt_lo = wr_en && (addr == ADDR_W'(A_CNT_LO));
    assign wr_cnt_hi = wr_en && (addr == ADDR_W'(A_CNT_HI));
    assign wr_wden   = wr_en && (addr == ADDR_W'(A_WDEN));

    pca_prescaler #(.PRESC(PRESC)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    pca_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (st_q.run),
        .tick_i  (tick),
        .wr_lo_i (wr_cnt_lo),
        .wr_hi_i (wr_cnt_hi),
        .wdata_i (wdata),
        .cnt_o   (cnt_o),
        .upd_o   (cnt_upd)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic wr_mode, wr_lo, wr_hi, clr;
        assign wr_mode = wr_en && (addr == ADDR_W'(A_MODE + ch));
        assign wr_lo   = wr_en && (addr == ADDR_W'(A_CMP + 2 * ch));
        assign wr_hi   = wr_en && (addr == ADDR_W'(A_CMP + 2 * ch + 1));
        assign clr     = wr_ctrl && !wdata[ch];

        pca_channel #(.PRESC(PRESC)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_i     (cnt_o),
            .cnt_upd_i (cnt_upd),
            .wr_mode_i (wr_mode),
            .wr_lo_i   (wr_lo),
            .wr_hi_i   (wr_hi),
            .clr_i     (clr),
            .wdata_i   (wdata),
            .flag_o    (flag_o[ch]),
            .ie_o      (ie[ch]),
            .hit_o     (hit[ch])
        );
    end

    always_comb begin
        st_d     = st_q;
        if (wr_ctrl) st_d.run  = wdata[RUN_BIT];
        if (wr_wden) st_d.wden = wdata[0];
        st_d.wdt = hit[WDT_CH] && st_q.wden && !st_q.wdt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o     = |(flag_o & ie);
    assign wdt_rst_o = st_q.wdt;

    assert_wdt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    assert_wdt_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> flag_o[WDT_CH]);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o != '0));
endmodule

// File: tb/pca_cmp_wdt_test.sv
module pca_cmp_wdt_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] cnt_o;
    logic [4:0]  flag_o;
    logic        irq_o, wdt_rst_o;

    int errors = 0;
    int checks = 0;
    int pulses = 0;

    pca_cmp_wdt uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) if (wdt_rst_o) pulses++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 flags", int'(flag_o), 0);
        check("R1 irq/wdt", int'({irq_o, wdt_rst_o}), 0);
    endtask

    task automatic t_wdt_config();
        int p0 = pulses;
        wr(8'h14, 8'h06);
        wr(8'h03, 8'h01);
        idle(20);
        check("R10 no pulse at config", pulses - p0, 0);
        check("R10 flag4 stays clear", int'(flag_o[4]), 0);
    endtask

    task automatic t_wdt_fire();
        int p0 = pulses;
        wr(8'h28, 8'h03);
        wr(8'h29, 8'h00);
        idle(3);
        check("R9 no pulse without match", pulses - p0, 0);
        wr(8'h01, 8'h03);
        idle(4);
        check("R9 one pulse", pulses - p0, 1);
        check("R9 flag4 set", int'(flag_o[4]), 1);
        wr(8'h03, 8'h00);
        idle(8);
        wr(8'h00, 8'h0F);
        check("R6 flag4 cleared after window", int'(flag_o[4]), 0);
        wr(8'h14, 8'h00);
    endtask

    task automatic t_cnt_write();
        wr(8'h02, 8'h01);
        check("R2 high byte", int'(cnt_o), 16'h0103);
        wr(8'h01, 8'h00);
        check("R2 low byte", int'(cnt_o), 16'h0100);
    endtask

    task automatic t_run();
        logic [15:0] v;
        wr(8'h00, 8'h9F);
        idle(60);
        check("R3 ten steps in 60 cycles", int'(cnt_o), 16'h010A);
        wr(8'h00, 8'h1F);
        v = cnt_o;
        idle(30);
        check("R3 hold when stopped", int'(cnt_o), int'(v));
    endtask

    task automatic t_flag_lock();
        wr(8'h02, 8'h02);
        wr(8'h01, 8'h00);
        wr(8'h10, 8'h07);
        wr(8'h20, 8'h05);
        wr(8'h21, 8'h02);
        check("R4 no flag before match", int'(flag_o[0]), 0);
        wr(8'h01, 8'h05);
        wr(8'h00, 8'h1E);
        wr(8'h00, 8'h1E);
        check("R4 flag set on stopped match", int'(flag_o[0]), 1);
        check("R8 irq with enabled flag", int'(irq_o), 1);
        check("R6 early clear ignored", int'(flag_o[0]), 1);
        idle(4);
        wr(8'h00, 8'h1E);
        check("R6 clear on last locked cycle ignored", int'(flag_o[0]), 1);
        wr(8'h00, 8'h1E);
        check("R6 clear after window", int'(flag_o[0]), 0);
        check("R8 irq drops", int'(irq_o), 0);
    endtask

    task automatic t_no_sw_set();
        wr(8'h00, 8'h1F);
        check("R11 writing ones sets nothing", int'(flag_o), 0);
    endtask

    task automatic t_atomic();
        wr(8'h11, 8'h07);
        wr(8'h22, 8'h05);
        wr(8'h02, 8'h00);
        idle(3);
        check("R7 low write disables compare", int'(flag_o[1]), 0);
        wr(8'h23, 8'h00);
        idle(2);
        check("R7 high write enables compare", int'(flag_o[1]), 1);
        idle(8);
        wr(8'h00, 8'h1D);
        wr(8'h11, 8'h00);
        check("R7 cleanup", int'(flag_o), 0);
    endtask

    task automatic t_no_match_en();
        wr(8'h12, 8'h05);
        wr(8'h24, 8'h08);
        wr(8'h25, 8'h00);
        wr(8'h01, 8'h08);
        idle(3);
        check("R5 no flag without match enable", int'(flag_o[2]), 0);
        check("R5 no irq", int'(irq_o), 0);
    endtask

    task automatic t_running_match();
        wr(8'h13, 8'h06);
        wr(8'h26, 8'h0C);
        wr(8'h27, 8'h00);
        wr(8'h00, 8'h9F);
        idle(40);
        wr(8'h00, 8'h1F);
        check("R4 flag from running counter", int'(flag_o), 5'b01000);
        check("R8 masked flag gives no irq", int'(irq_o), 0);
        wr(8'h13, 8'h07);
        check("R8 irq after enable", int'(irq_o), 1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_wdt_config();
        t_wdt_fire();
        t_cnt_write();
        t_run();
        t_flag_lock();
        t_no_sw_set();
        t_atomic();
        t_no_match_en();
        t_running_match();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule